// File: doc/BRIEF.md
# Hardware Task Switch Sequencer

This block performs a task switch on behalf of a processor core. A request names a cause and a selector. The sequencer looks up that selector through a descriptor lookup port. When the cause is a gate, it first resolves the gate to the state-segment selector the gate points at. It then checks privilege, presence, kind and size. If the checks pass, it writes the outgoing task's context words to that task's state area, and loads the task register with the incoming selector, base and limit. For a nesting cause it records the outgoing selector in the incoming task's area. Finally it reads the incoming task's link, flags and context words. All memory traffic goes through a single request/acknowledge port.

Each task state area is laid out as word 0 holding the back-link selector (low 16 bits), word 1 holding the flags word (bit 0 is the nested-task flag), and words 2 onward holding the context words. Words are 4 bytes apart. A return cause (IRET) is only taken while the nested-task flag is set. It switches back to the task named by the current task's back-link.

Top module: `task_switch_ctrl`

## Requirements
- R1: After synchronous reset the task register selector, base and limit are 0, the nested-task flag is 0, busy, done and fault_valid are low, mem_req is low, and ctx_load is all zeros.
- R2: For gate causes other than interrupt (cause 2 JMP-gate, 3 CALL-gate), and for direct causes (0 JMP-descriptor, 1 CALL-descriptor), the switch faults with code 1 unless max(request selector bits [1:0], cpl) <= the looked-up descriptor's privilege field. The RPL bits of a gate's target selector take part in no check. Cause 4 (interrupt via gate) and cause 5 (IRET) skip the privilege check.
- R3: A failed check aborts before any memory request, leaves the task register unchanged and pulses fault_valid with a code. The codes are 2 for a descriptor that is not present, 3 for a state-area limit below (CTX_WORDS+2)*4-1, and 4 for a kind mismatch (a gate cause naming a non-gate, or a non-gate stage naming a gate). A limit exactly equal to the minimum is accepted.
- R4: Before the task register changes, the outgoing flags word is written at old base+4 and context word i at old base+8+4*i.
- R5: After a switch the task register selector equals the target selector with bits [1:0] cleared (the gate's target for gate causes), and the base and limit equal the target descriptor's; the selector never changes while busy is low.
- R6: Causes 1, 3 and 4 write the outgoing selector into word 0 of the incoming area and leave the nested-task flag set.
- R7: Causes 0 and 2 write no back-link, and the nested-task flag is taken from bit 0 of the incoming flags word.
- R8: Cause 5 with the nested-task flag set switches to the task named by the back-link, saving the outgoing flags word with bit 0 cleared; cause 5 with the flag clear is ignored.
- R9: ctx_load word i holds the word read from new base+8+4*i when done pulses.
- R10: A memory request keeps mem_req high with stable address, direction and write data until mem_ack.
- R11: busy rises the cycle after an accepted trigger and stays high until the done or fault cycle. Triggers seen while busy are ignored, and done and fault_valid never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_valid | input | 1 | Switch request strobe |
| trig_cause | input | 3 | Cause code 0..5 (see R2) |
| trig_sel | input | SEL_W | Descriptor or gate selector of the request |
| cpl | input | 2 | Current privilege level at the request |
| ctx_save | input | CTX_WORDS*DATA_W | Outgoing context words, word i at bits i*DATA_W |
| dt_sel | output | SEL_W | Selector presented to the descriptor lookup |
| dt_present | input | 1 | Looked-up descriptor is present |
| dt_gate | input | 1 | Looked-up descriptor is a task gate |
| dt_dpl | input | 2 | Looked-up descriptor privilege field |
| dt_base | input | ADDR_W | State-area base of the looked-up descriptor |
| dt_limit | input | ADDR_W | State-area byte limit of the looked-up descriptor |
| dt_gate_sel | input | SEL_W | Target selector held in a gate |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Request completed (read data valid) |
| mem_rdata | input | DATA_W | Read data |
| tr_sel | output | SEL_W | Visible task register selector |
| tr_base | output | ADDR_W | Cached state-area base |
| tr_limit | output | ADDR_W | Cached state-area limit |
| nt_flag | output | 1 | Nested-task flag |
| ctx_load | output | CTX_WORDS*DATA_W | Incoming context words |
| busy | output | 1 | Switch in progress |
| done | output | 1 | One-cycle switch completion |
| fault_valid | output | 1 | One-cycle abort strobe |
| fault_code | output | 3 | Failing check, valid with fault_valid |

## Verification
The assertions take for granted that ctx_save is held steady for the whole of a switch. Without that, the write data of a pending save could move while mem_req waits for its acknowledge. They also take for granted that mem_ack is only raised in answer to a pending request and for one cycle. The descriptor port is assumed to answer combinationally for the selector on dt_sel. The stimulus sets ctx_save before each trigger and changes it only after done or fault. Its memory model raises a single-cycle acknowledge a fixed three cycles into each request. Its descriptor table is a fixed combinational lookup.

// File: rtl/tsw_pkg.sv
// Shared types for the task switch sequencer: request causes, fault codes
// and sequencer states, plus helpers that classify causes.
package tsw_pkg;

    typedef enum logic [2:0] {
        CS_JMP_DESC  = 3'd0,
        CS_CALL_DESC = 3'd1,
        CS_JMP_GATE  = 3'd2,
        CS_CALL_GATE = 3'd3,
        CS_INTR_GATE = 3'd4,
        CS_IRET      = 3'd5
    } cause_e;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_PRIV   = 3'd1,
        FLT_ABSENT = 3'd2,
        FLT_LIMIT  = 3'd3,
        FLT_KIND   = 3'd4
    } fault_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GATE,
        ST_DESC,
        ST_SAVE,
        ST_SWAP,
        ST_LINK,
        ST_LOAD,
        ST_RESUME,
        ST_FAULT
    } state_e;

    // True when the cause reaches its target through a gate descriptor.
    function automatic logic cause_via_gate(cause_e c);
        return (c == CS_JMP_GATE) || (c == CS_CALL_GATE) || (c == CS_INTR_GATE);
    endfunction

    // True when the cause nests the new task under the old one.
    function automatic logic cause_nests(cause_e c);
        return (c == CS_CALL_DESC) || (c == CS_CALL_GATE) || (c == CS_INTR_GATE);
    endfunction

endpackage

// File: rtl/tsw_access_check.sv
// Combinational check of one looked-up descriptor. Assumes the descriptor
// fields are valid for the selector being checked in the current cycle.
// Priority: kind, privilege, presence, limit.
module tsw_access_check
    import tsw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MIN_LIMIT = 23
) (
    input  logic              expect_gate,
    input  logic              do_priv,
    input  logic              check_limit,
    input  logic [1:0]        rpl,
    input  logic [1:0]        cpl,
    input  logic [1:0]        dpl,
    input  logic              present,
    input  logic              is_gate,
    input  logic [ADDR_W-1:0] limit,
    output fault_e            fault
);

    logic [1:0] eff_pl;

    // Effective privilege is the weaker of requester and current level.
    always_comb eff_pl = (rpl > cpl) ? rpl : cpl;

    // Pick the first failing check in priority order.
    always_comb begin
        if (is_gate != expect_gate)
            fault = FLT_KIND;
        else if (do_priv && (eff_pl > dpl))
            fault = FLT_PRIV;
        else if (!present)
            fault = FLT_ABSENT;
        else if (check_limit && (limit < ADDR_W'(MIN_LIMIT)))
            fault = FLT_LIMIT;
        else
            fault = FLT_NONE;
    end

endmodule

// File: rtl/tsw_task_reg.sv
// Task register model: visible selector with hidden cached base and limit,
// plus the nested-task flag and the current task's back-link selector.
// Each field has its own write enable driven by the sequencer.
module tsw_task_reg #(
    parameter int SEL_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tr_we,
    input  logic [SEL_W-1:0]  tr_sel_d,
    input  logic [ADDR_W-1:0] tr_base_d,
    input  logic [ADDR_W-1:0] tr_limit_d,
    input  logic              nt_we,
    input  logic              nt_d,
    input  logic              link_we,
    input  logic [SEL_W-1:0]  link_d,
    output logic [SEL_W-1:0]  tr_sel,
    output logic [ADDR_W-1:0] tr_base,
    output logic [ADDR_W-1:0] tr_limit,
    output logic              nt,
    output logic [SEL_W-1:0]  link
);

    // Selector and hidden base/limit are refreshed together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tr_sel   <= '0;
            tr_base  <= '0;
            tr_limit <= '0;
        end else if (tr_we) begin
            tr_sel   <= tr_sel_d;
            tr_base  <= tr_base_d;
            tr_limit <= tr_limit_d;
        end
    end

    // Nested-task flag.
    always_ff @(posedge clk) begin
        if (!rst_n)     nt <= 1'b0;
        else if (nt_we) nt <= nt_d;
    end

    // Back-link of the current task.
    always_ff @(posedge clk) begin
        if (!rst_n)       link <= '0;
        else if (link_we) link <= link_d;
    end

endmodule

// File: rtl/tsw_mem_port.sv
// Forms the memory request for the current save, link or load step.
// Assumes at most one of do_save/do_link/do_load is high. Layout per task:
// word 0 back-link, word 1 flags (bit 0 nested flag), words 2.. context.
module tsw_mem_port #(
    parameter int SEL_W     = 16,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int CTX_WORDS = 4,
    parameter int IDX_W     = 3
) (
    input  logic                        do_save,
    input  logic                        do_link,
    input  logic                        do_load,
    input  logic [IDX_W-1:0]            idx,
    input  logic [ADDR_W-1:0]           old_base,
    input  logic [ADDR_W-1:0]           new_base,
    input  logic                        nt_save,
    input  logic [SEL_W-1:0]            old_sel,
    input  logic [CTX_WORDS*DATA_W-1:0] ctx_save,
    output logic                        req,
    output logic                        we,
    output logic [ADDR_W-1:0]           addr,
    output logic [DATA_W-1:0]           wdata
);

    localparam int WORD_BYTES = DATA_W / 8;

    logic [DATA_W-1:0] ctx_w [CTX_WORDS];
    logic [ADDR_W-1:0] word_off;
    logic [DATA_W-1:0] save_word;

    // Split the flat context bus into words.
    for (genvar w = 0; w < CTX_WORDS; w++) begin : g_ctx
        assign ctx_w[w] = ctx_save[w*DATA_W +: DATA_W];
    end

    // Byte offset of word idx inside a state area.
    always_comb word_off = ADDR_W'(idx) * ADDR_W'(WORD_BYTES);

    // Save step idx 0 is the flags word, idx k is context word k-1.
    always_comb begin
        save_word = {{(DATA_W-1){1'b0}}, nt_save};
        for (int i = 0; i < CTX_WORDS; i++)
            if (idx == IDX_W'(i + 1)) save_word = ctx_w[i];
    end

    // Drive the request for whichever step is active.
    always_comb begin
        req   = do_save | do_link | do_load;
        we    = do_save | do_link;
        addr  = '0;
        wdata = '0;
        if (do_save) begin
            addr  = old_base + ADDR_W'(WORD_BYTES) + word_off;
            wdata = save_word;
        end else if (do_link) begin
            addr  = new_base;
            wdata = DATA_W'(old_sel);
        end else if (do_load) begin
            addr  = new_base + word_off;
        end
    end

endmodule

// File: rtl/task_switch_ctrl.sv
// Task switch sequencer. Accepts a cause and selector, resolves a gate if
// present, checks the target, saves the outgoing context, loads the task
// register, writes the back-link for nesting causes and reads the incoming
// task. Assumes the descriptor port answers in the same cycle and that
// ctx_save is held steady while busy.
module task_switch_ctrl
    import tsw_pkg::*;
#(
    parameter int SEL_W     = 16,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int CTX_WORDS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        trig_valid,
    input  logic [2:0]                  trig_cause,
    input  logic [SEL_W-1:0]            trig_sel,
    input  logic [1:0]                  cpl,
    input  logic [CTX_WORDS*DATA_W-1:0] ctx_save,
    output logic [SEL_W-1:0]            dt_sel,
    input  logic                        dt_present,
    input  logic                        dt_gate,
    input  logic [1:0]                  dt_dpl,
    input  logic [ADDR_W-1:0]           dt_base,
    input  logic [ADDR_W-1:0]           dt_limit,
    input  logic [SEL_W-1:0]            dt_gate_sel,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [DATA_W-1:0]           mem_wdata,
    input  logic                        mem_ack,
    input  logic [DATA_W-1:0]           mem_rdata,
    output logic [SEL_W-1:0]            tr_sel,
    output logic [ADDR_W-1:0]           tr_base,
    output logic [ADDR_W-1:0]           tr_limit,
    output logic                        nt_flag,
    output logic [CTX_WORDS*DATA_W-1:0] ctx_load,
    output logic                        busy,
    output logic                        done,
    output logic                        fault_valid,
    output logic [2:0]                  fault_code
);

    localparam int WORD_BYTES = DATA_W / 8;
    localparam int AREA_WORDS = CTX_WORDS + 2;
    localparam int MIN_LIMIT  = AREA_WORDS * WORD_BYTES - 1;
    localparam int IDX_W      = $clog2(AREA_WORDS);
    localparam logic [IDX_W-1:0] SAVE_LAST = IDX_W'(CTX_WORDS);
    localparam logic [IDX_W-1:0] LOAD_LAST = IDX_W'(CTX_WORDS + 1);
    localparam logic [SEL_W-1:0] RPL_MASK  = ~SEL_W'(3);

    state_e            state;
    cause_e            cause_q;
    logic [SEL_W-1:0]  req_sel_q;
    logic [SEL_W-1:0]  tgt_sel_q;
    logic [SEL_W-1:0]  old_sel_q;
    logic [1:0]        cpl_q;
    logic [ADDR_W-1:0] new_base_q;
    logic [ADDR_W-1:0] new_limit_q;
    logic [IDX_W-1:0]  idx_q;
    fault_e            fault_q;
    fault_e            chk_fault;
    cause_e            trig_cause_e;
    logic              cause_ok;
    logic              accept;
    logic              chk_do_priv;
    logic              load_hit;
    logic [SEL_W-1:0]  link_sel;
    logic [DATA_W-1:0] ctx_r [CTX_WORDS];

    // Decode the incoming request and decide whether it is taken.
    always_comb begin
        trig_cause_e = cause_e'(trig_cause);
        cause_ok     = (trig_cause <= 3'd5);
        accept       = (state == ST_IDLE) && trig_valid && cause_ok &&
                       ((trig_cause_e != CS_IRET) || nt_flag);
    end

    // Gate stage checks the gate; the descriptor stage checks the target.
    always_comb begin
        dt_sel = (state == ST_GATE) ? req_sel_q : tgt_sel_q;
        if (state == ST_GATE)
            chk_do_priv = (cause_q != CS_INTR_GATE);
        else
            chk_do_priv = (cause_q == CS_JMP_DESC) || (cause_q == CS_CALL_DESC);
    end

    tsw_access_check #(
        .ADDR_W    (ADDR_W),
        .MIN_LIMIT (MIN_LIMIT)
    ) u_check (
        .expect_gate (state == ST_GATE),
        .do_priv     (chk_do_priv),
        .check_limit (state == ST_DESC),
        .rpl         (req_sel_q[1:0]),
        .cpl         (cpl_q),
        .dpl         (dt_dpl),
        .present     (dt_present),
        .is_gate     (dt_gate),
        .limit       (dt_limit),
        .fault       (chk_fault)
    );

    // Main sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cause_q     <= CS_JMP_DESC;
            req_sel_q   <= '0;
            tgt_sel_q   <= '0;
            old_sel_q   <= '0;
            cpl_q       <= '0;
            new_base_q  <= '0;
            new_limit_q <= '0;
            idx_q       <= '0;
            fault_q     <= FLT_NONE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cause_q   <= trig_cause_e;
                        req_sel_q <= trig_sel;
                        cpl_q     <= cpl;
                        old_sel_q <= tr_sel;
                        idx_q     <= '0;
                        tgt_sel_q <= (trig_cause_e == CS_IRET) ? link_sel : trig_sel;
                        state     <= cause_via_gate(trig_cause_e) ? ST_GATE : ST_DESC;
                    end
                end
                ST_GATE: begin
                    if (chk_fault != FLT_NONE) begin
                        fault_q <= chk_fault;
                        state   <= ST_FAULT;
                    end else begin
                        tgt_sel_q <= dt_gate_sel;
                        state     <= ST_DESC;
                    end
                end
                ST_DESC: begin
                    if (chk_fault != FLT_NONE) begin
                        fault_q <= chk_fault;
                        state   <= ST_FAULT;
                    end else begin
                        new_base_q  <= dt_base;
                        new_limit_q <= dt_limit;
                        tgt_sel_q   <= tgt_sel_q & RPL_MASK;
                        state       <= ST_SAVE;
                    end
                end
                ST_SAVE: begin
                    if (mem_ack) begin
                        if (idx_q == SAVE_LAST) begin
                            idx_q <= '0;
                            state <= ST_SWAP;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_SWAP: begin
                    state <= cause_nests(cause_q) ? ST_LINK : ST_LOAD;
                end
                ST_LINK: begin
                    if (mem_ack) state <= ST_LOAD;
                end
                ST_LOAD: begin
                    if (mem_ack) begin
                        if (idx_q == LOAD_LAST) begin
                            idx_q <= '0;
                            state <= ST_RESUME;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_RESUME: state <= ST_IDLE;
                ST_FAULT:  state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // A completed read during the load phase.
    always_comb load_hit = (state == ST_LOAD) && mem_ack;

    tsw_task_reg #(
        .SEL_W  (SEL_W),
        .ADDR_W (ADDR_W)
    ) u_treg (
        .clk        (clk),
        .rst_n      (rst_n),
        .tr_we      (state == ST_SWAP),
        .tr_sel_d   (tgt_sel_q),
        .tr_base_d  (new_base_q),
        .tr_limit_d (new_limit_q),
        .nt_we      (load_hit && (idx_q == IDX_W'(1))),
        .nt_d       (cause_nests(cause_q) | mem_rdata[0]),
        .link_we    (load_hit && (idx_q == '0)),
        .link_d     (mem_rdata[SEL_W-1:0]),
        .tr_sel     (tr_sel),
        .tr_base    (tr_base),
        .tr_limit   (tr_limit),
        .nt         (nt_flag),
        .link       (link_sel)
    );

    tsw_mem_port #(
        .SEL_W     (SEL_W),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CTX_WORDS (CTX_WORDS),
        .IDX_W     (IDX_W)
    ) u_mport (
        .do_save  (state == ST_SAVE),
        .do_link  (state == ST_LINK),
        .do_load  (state == ST_LOAD),
        .idx      (idx_q),
        .old_base (tr_base),
        .new_base (new_base_q),
        .nt_save  ((cause_q == CS_IRET) ? 1'b0 : nt_flag),
        .old_sel  (old_sel_q),
        .ctx_save (ctx_save),
        .req      (mem_req),
        .we       (mem_we),
        .addr     (mem_addr),
        .wdata    (mem_wdata)
    );

    // Incoming context words, captured as each read completes.
    for (genvar w = 0; w < CTX_WORDS; w++) begin : g_load
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctx_r[w] <= '0;
            else if (load_hit && (idx_q == IDX_W'(w + 2)))
                ctx_r[w] <= mem_rdata;
        end
        assign ctx_load[w*DATA_W +: DATA_W] = ctx_r[w];
    end

    // Status outputs follow the sequencer state.
    always_comb begin
        busy        = (state != ST_IDLE);
        done        = (state == ST_RESUME);
        fault_valid = (state == ST_FAULT);
        fault_code  = (state == ST_FAULT) ? fault_q : FLT_NONE;
    end

endmodule

// File: rtl/tsw_assert_chk.sv
// Protocol and sequencing properties for the task switch sequencer,
// attached to every instance by the bind below.
module tsw_assert_chk #(
    parameter int SEL_W  = 16,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_valid,
    input logic [2:0]        trig_cause,
    input logic              busy,
    input logic              done,
    input logic              fault_valid,
    input logic [2:0]        fault_code,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [SEL_W-1:0]  tr_sel,
    input logic              nt_flag
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R11

    AST_TR_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(tr_sel)); // R5

    AST_FAULT_CODED: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (fault_code != 3'd0) && !mem_req); // R3

    AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault_valid)); // R11

    AST_IRET_FLAT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid && !busy && (trig_cause == 3'd5) && !nt_flag |=> !busy); // R8

    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid && !busy && (trig_cause < 3'd5) |=> busy); // R11

endmodule

bind task_switch_ctrl tsw_assert_chk #(
    .SEL_W  (SEL_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_valid  (trig_valid),
    .trig_cause  (trig_cause),
    .busy        (busy),
    .done        (done),
    .fault_valid (fault_valid),
    .fault_code  (fault_code),
    .mem_req     (mem_req),
    .mem_ack     (mem_ack),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .tr_sel      (tr_sel),
    .nt_flag     (nt_flag)
);

// File: tb/tb_task_switch_ctrl.sv
// Directed bench for the task switch sequencer: one task per scenario.
module tb_task_switch_ctrl;

    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_valid = 1'b0;
    logic [2:0]    trig_cause = 3'd0;
    logic [15:0]   trig_sel = '0;
    logic [1:0]    cpl = 2'd0;
    logic [NW*32-1:0] ctx_save = '0;
    logic [15:0]   dt_sel;
    logic          dt_present, dt_gate;
    logic [1:0]    dt_dpl;
    logic [31:0]   dt_base, dt_limit;
    logic [15:0]   dt_gate_sel;
    logic          mem_req, mem_we;
    logic [31:0]   mem_addr, mem_wdata;
    logic          mem_ack;
    logic [31:0]   mem_rdata;
    logic [15:0]   tr_sel;
    logic [31:0]   tr_base, tr_limit;
    logic          nt_flag;
    logic [NW*32-1:0] ctx_load;
    logic          busy, done, fault_valid;
    logic [2:0]    fault_code;

    int vectors = 0;
    int miscmp = 0;

    always #2.5 clk = ~clk;

    task_switch_ctrl dut (
        .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_cause(trig_cause),
        .trig_sel(trig_sel), .cpl(cpl), .ctx_save(ctx_save), .dt_sel(dt_sel),
        .dt_present(dt_present), .dt_gate(dt_gate), .dt_dpl(dt_dpl), .dt_base(dt_base),
        .dt_limit(dt_limit), .dt_gate_sel(dt_gate_sel), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tr_sel(tr_sel), .tr_base(tr_base), .tr_limit(tr_limit), .nt_flag(nt_flag),
        .ctx_load(ctx_load), .busy(busy), .done(done), .fault_valid(fault_valid),
        .fault_code(fault_code)
    );

    // Descriptor table, indexed by selector bits [6:3].
    logic        tp [16];
    logic        tg [16];
    logic [1:0]  td [16];
    logic [31:0] tb_ [16];
    logic [31:0] tl [16];
    logic [15:0] ts [16];

    always_comb begin
        dt_present  = tp[dt_sel[6:3]];
        dt_gate     = tg[dt_sel[6:3]];
        dt_dpl      = td[dt_sel[6:3]];
        dt_base     = tb_[dt_sel[6:3]];
        dt_limit    = tl[dt_sel[6:3]];
        dt_gate_sel = ts[dt_sel[6:3]];
    end

    // Memory model: acknowledge three cycles into each request.
    logic [31:0] mem [1024];
    logic        pl_we = 1'b0;
    logic [31:0] pl_a = '0, pl_d = '0;
    int          wcnt = 0;
    int          nwrites = 0;
    int          naccess = 0;
    int          proto_err = 0;
    logic        prev_req = 1'b0, prev_ack = 1'b0;
    logic [31:0] prev_addr = '0;

    always @(posedge clk) begin
        if (pl_we) mem[pl_a[11:2]] <= pl_d;
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
            wcnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            wcnt <= 0;
        end else if (mem_req) begin
            if (wcnt == 2) begin
                mem_ack <= 1'b1;
                naccess <= naccess + 1;
                if (mem_we) begin
                    mem[mem_addr[11:2]] <= mem_wdata;
                    nwrites <= nwrites + 1;
                end else begin
                    mem_rdata <= mem[mem_addr[11:2]];
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end
        // Handshake watch for R10: a pending request may not drop or move.
        if (rst_n && prev_req && !prev_ack && (!mem_req || mem_addr != prev_addr))
            proto_err <= proto_err + 1;
        prev_req  <= mem_req;
        prev_ack  <= mem_ack;
        prev_addr <= mem_addr;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        pl_we = 1'b1; pl_a = a; pl_d = d;
        @(negedge clk);
        pl_we = 1'b0;
    endtask

    task automatic set_desc(input int i, input logic p, input logic g, input logic [1:0] d,
                            input logic [31:0] b, input logic [31:0] l, input logic [15:0] s);
        tp[i] = p; tg[i] = g; td[i] = d; tb_[i] = b; tl[i] = l; ts[i] = s;
    endtask

    function automatic logic [NW*32-1:0] pattern(input logic [31:0] seed);
        logic [NW*32-1:0] v;
        for (int i = 0; i < NW; i++) v[i*32 +: 32] = seed + 32'(i);
        return v;
    endfunction

    // Issue one trigger and wait for done or fault.
    task automatic fire(input logic [2:0] c, input logic [15:0] s, input logic [1:0] p,
                        output logic ok, output logic [2:0] fc);
        ok = 1'b0; fc = 3'd0;
        @(negedge clk);
        trig_valid = 1'b1; trig_cause = c; trig_sel = s; cpl = p;
        @(negedge clk);
        trig_valid = 1'b0;
        chk("R11 busy after accept", 32'(busy), 32'd1);
        for (int n = 0; n < 400; n++) begin
            if (done) begin ok = 1'b1; break; end
            if (fault_valid) begin fc = fault_code; break; end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic chk_ctx(input string tag, input logic [NW*32-1:0] exp);
        for (int i = 0; i < NW; i++) chk(tag, ctx_load[i*32 +: 32], exp[i*32 +: 32]);
    endtask

    task automatic chk_saved(input string tag, input logic [31:0] base, input logic [NW*32-1:0] exp);
        for (int i = 0; i < NW; i++) chk(tag, mem[(base + 32'd8 + 32'(4*i)) >> 2], exp[i*32 +: 32]);
    endtask

    task automatic expect_fault(input string tag, input logic [2:0] c, input logic [15:0] s,
                                input logic [1:0] p, input logic [2:0] code);
        logic ok; logic [2:0] fc; int a0; logic [15:0] t0;
        a0 = naccess; t0 = tr_sel;
        fire(c, s, p, ok, fc);
        chk(tag, 32'(fc), 32'(code));
        chk("R3 no memory access on fault", 32'(naccess - a0), 32'd0);
        chk("R3 task register kept on fault", 32'(tr_sel), 32'(t0));
    endtask

    task automatic t_reset();
        chk("R1 tr_sel", 32'(tr_sel), 32'd0);
        chk("R1 tr_base", tr_base, 32'd0);
        chk("R1 tr_limit", tr_limit, 32'd0);
        chk("R1 nt", 32'(nt_flag), 32'd0);
        chk("R1 busy/done/fault/req", {28'd0, busy, done, fault_valid, mem_req}, 32'd0);
        chk("R1 ctx_load", 32'(|ctx_load), 32'd0);
    endtask

    task automatic t_jmp_direct();
        logic ok; logic [2:0] fc; int w0;
        ctx_save = pattern(32'h5000_0000);
        w0 = nwrites;
        fire(3'd0, 16'h0008, 2'd3, ok, fc);
        chk("R5 jmp done", 32'(ok), 32'd1);
        chk("R4 flags saved", mem[1], 32'd0);
        chk_saved("R4 ctx saved", 32'h0, pattern(32'h5000_0000));
        chk("R5 tr_sel", 32'(tr_sel), 32'h0008);
        chk("R5 tr_base", tr_base, 32'h100);
        chk("R5 tr_limit", tr_limit, 32'h2F);
        chk("R7 nt from flags", 32'(nt_flag), 32'd0);
        chk("R7 no link write", mem[32'h100 >> 2], 32'hAAAA_0000);
        chk("R7 write count", 32'(nwrites - w0), 32'd5);
        chk_ctx("R9 ctx loaded", pattern(32'hA000_0000));
    endtask

    task automatic t_call_gate();
        logic ok; logic [2:0] fc; int w0;
        ctx_save = pattern(32'h5100_0000);
        w0 = nwrites;
        fire(3'd3, 16'h0020, 2'd3, ok, fc);
        chk("R2 gate target rpl ignored", 32'(ok), 32'd1);
        chk_saved("R4 ctx saved A", 32'h100, pattern(32'h5100_0000));
        chk("R6 back-link", mem[32'h200 >> 2], 32'h0008);
        chk("R6 nt set", 32'(nt_flag), 32'd1);
        chk("R5 tr_sel rpl cleared", 32'(tr_sel), 32'h0010);
        chk("R5 tr_base", tr_base, 32'h200);
        chk("R6 write count", 32'(nwrites - w0), 32'd6);
        chk_ctx("R9 ctx loaded B", pattern(32'hB000_0000));
    endtask

    task automatic t_iret_nested();
        logic ok; logic [2:0] fc;
        ctx_save = pattern(32'h5200_0000);
        fire(3'd5, 16'h0000, 2'd0, ok, fc);
        chk("R8 iret done", 32'(ok), 32'd1);
        chk("R8 outgoing nt cleared", mem[32'h204 >> 2], 32'd0);
        chk_saved("R4 ctx saved B", 32'h200, pattern(32'h5200_0000));
        chk("R8 returned to link", 32'(tr_sel), 32'h0008);
        chk("R8 nt from A flags", 32'(nt_flag), 32'd0);
        chk_ctx("R9 ctx restored A", pattern(32'h5100_0000));
    endtask

    task automatic t_iret_flat();
        int a0;
        a0 = naccess;
        @(negedge clk);
        trig_valid = 1'b1; trig_cause = 3'd5; trig_sel = 16'h0; cpl = 2'd0;
        @(negedge clk);
        trig_valid = 1'b0;
        for (int n = 0; n < 6; n++) begin
            chk("R8 flat iret ignored busy", 32'(busy), 32'd0);
            @(negedge clk);
        end
        chk("R8 flat iret tr_sel", 32'(tr_sel), 32'h0008);
        chk("R8 flat iret no access", 32'(naccess - a0), 32'd0);
    endtask

    task automatic t_priv();
        logic ok; logic [2:0] fc;
        expect_fault("R2 gate dpl below cpl", 3'd3, 16'h0028, 2'd3, 3'd1);
        expect_fault("R2 selector rpl above gate dpl", 3'd2, 16'h004B, 2'd0, 3'd1);
        expect_fault("R2 direct dpl below cpl", 3'd0, 16'h0010, 2'd1, 3'd1);
        ctx_save = pattern(32'h5300_0000);
        fire(3'd2, 16'h004A, 2'd1, ok, fc);
        chk("R2 rpl equal gate dpl accepted", 32'(ok), 32'd1);
        chk("R5 tr_sel C", 32'(tr_sel), 32'h0018);
        chk("R7 nt from C flags", 32'(nt_flag), 32'd1);
        chk("R7 no link write C", mem[32'h300 >> 2], 32'hCCCC_0000);
    endtask

    task automatic t_checks();
        logic ok; logic [2:0] fc;
        expect_fault("R3 not present", 3'd0, 16'h0030, 2'd0, 3'd2);
        expect_fault("R3 limit one short", 3'd0, 16'h0038, 2'd0, 3'd3);
        expect_fault("R3 direct names gate", 3'd0, 16'h0020, 2'd0, 3'd4);
        expect_fault("R3 gate cause names tss", 3'd2, 16'h0008, 2'd0, 3'd4);
        ctx_save = pattern(32'h5400_0000);
        fire(3'd0, 16'h0040, 2'd0, ok, fc);
        chk("R3 limit at minimum accepted", 32'(ok), 32'd1);
        chk("R5 tr_limit D", tr_limit, 32'h17);
        chk("R5 tr_base D", tr_base, 32'h380);
    endtask

    task automatic t_interrupt();
        logic ok; logic [2:0] fc;
        ctx_save = pattern(32'h5500_0000);
        fire(3'd4, 16'h0028, 2'd3, ok, fc);
        chk("R2 interrupt skips privilege", 32'(ok), 32'd1);
        chk("R6 interrupt back-link", mem[32'h300 >> 2], 32'h0040);
        chk("R6 interrupt nt", 32'(nt_flag), 32'd1);
        chk("R5 tr_sel after interrupt", 32'(tr_sel), 32'h0018);
    endtask

    task automatic t_busy_ignore();
        int w0; logic got;
        ctx_save = pattern(32'h5600_0000);
        w0 = nwrites; got = 1'b0;
        @(negedge clk);
        trig_valid = 1'b1; trig_cause = 3'd0; trig_sel = 16'h0008; cpl = 2'd0;
        @(negedge clk);
        trig_valid = 1'b0;
        repeat (4) @(negedge clk);
        trig_valid = 1'b1; trig_cause = 3'd1; trig_sel = 16'h0010;
        @(negedge clk);
        trig_valid = 1'b0;
        for (int n = 0; n < 400; n++) begin
            if (done) begin got = 1'b1; break; end
            @(negedge clk);
        end
        chk("R11 switch completed", 32'(got), 32'd1);
        repeat (6) @(negedge clk);
        chk("R11 no second switch", 32'(busy), 32'd0);
        chk("R11 tr_sel from first trigger", 32'(tr_sel), 32'h0008);
        chk("R11 writes of one jmp only", 32'(nwrites - w0), 32'd5);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscmp++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) set_desc(i, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0, 16'h0);
        set_desc(1, 1'b1, 1'b0, 2'd3, 32'h100, 32'h2F, 16'h0);
        set_desc(2, 1'b1, 1'b0, 2'd0, 32'h200, 32'h2F, 16'h0);
        set_desc(3, 1'b1, 1'b0, 2'd0, 32'h300, 32'h2F, 16'h0);
        set_desc(4, 1'b1, 1'b1, 2'd3, 32'h0, 32'h0, 16'h0013);
        set_desc(5, 1'b1, 1'b1, 2'd0, 32'h0, 32'h0, 16'h0018);
        set_desc(6, 1'b0, 1'b0, 2'd3, 32'h3C0, 32'h2F, 16'h0);
        set_desc(7, 1'b1, 1'b0, 2'd3, 32'h3C0, 32'h16, 16'h0);
        set_desc(8, 1'b1, 1'b0, 2'd3, 32'h380, 32'h17, 16'h0);
        set_desc(9, 1'b1, 1'b1, 2'd2, 32'h0, 32'h0, 16'h0018);
        for (int i = 0; i < 1024; i++) begin
            pl_we = 1'b1; pl_a = 32'(i * 4); pl_d = 32'h0;
            @(negedge clk);
        end
        pl_we = 1'b0;
        poke(32'h100, 32'hAAAA_0000); poke(32'h104, 32'h0);
        poke(32'h200, 32'h0000_DEAD); poke(32'h204, 32'h0);
        poke(32'h300, 32'hCCCC_0000); poke(32'h304, 32'h1);
        poke(32'h380, 32'h0);         poke(32'h384, 32'h0);
        for (int i = 0; i < NW; i++) begin
            poke(32'h108 + 32'(4*i), 32'hA000_0000 + 32'(i));
            poke(32'h208 + 32'(4*i), 32'hB000_0000 + 32'(i));
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_jmp_direct();
        t_call_gate();
        t_iret_nested();
        t_iret_flat();
        t_priv();
        t_checks();
        t_interrupt();
        t_busy_ignore();
        chk("R10 handshake held until ack", 32'(proto_err), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

endmodule